// File: doc/BRIEF.md
# Wedge Detector for a Two-Wall Trap

This block watches the drive commands of a small maze-exploring robot and recognises the moment it is trapped between two walls. In that trap the robot keeps alternating short reverse and forward moves without ever getting free. Each motion command is presented on a one-cycle update strobe. The block follows a reverse command that is answered by a forward command, and treats that pair as one alternation cycle. Each completed cycle pulses an increment for a small 2-bit counter that sits outside the block. The counter's terminal-count flag comes back in as an input.

Once the counter reaches its top value, the block enters an escape state. In that state it raises a valid flag for the motion arbiter and a start request for the movement timer. It holds both until the timer reports completion, and then returns to idle. The idle state drives the counter's synchronous clear, so any break in the alternation pattern restarts the count. All four outputs come from the present state alone.

Top module: `wedge_detect`

## Requirements
- R1: Driving `rst_n` low forces idle at once, without waiting for a clock. Idle means `cnt_clr`=1 and `esc_valid`=`tmr_start`=`cnt_en`=0. After `rst_n` rises, the machine stays idle for `SYNC_STAGES` rising edges (default 2) before it responds to inputs.
- R2: While `upd_stb` is low, `fwd_cmd` and `bwd_cmd` do not change the state.
- R3: In idle, an update with `bwd_cmd` high moves to tracking, where all four outputs are 0. An update with only `fwd_cmd` high, or with neither command high, leaves the machine idle.
- R4: In tracking, an update with `fwd_cmd` high moves to a count state. This happens even when `bwd_cmd` is also high. The count state drives `cnt_en`=1 for exactly one cycle, and the machine then moves to a hold state whatever the inputs are.
- R5: In tracking, an update with `bwd_cmd` alone keeps tracking. An update with neither command high returns to idle.
- R6: In hold, an update with `bwd_cmd` high returns to tracking and leaves the counter uncleared. An update without `bwd_cmd` returns to idle.
- R7: `cnt_clr` is high in every idle cycle and in no other state. After any return to idle, three further complete alternation cycles are needed to reach escape.
- R8: In hold, `cnt_tc`=1 (counter value 2'b11) moves to escape on the next edge. This takes priority over any update input in the same cycle.
- R9: In escape, `esc_valid` and `tmr_start` are both 1. The state holds while `tmr_done` is 0. With `tmr_done`=1, the next state is idle. Command and update inputs are ignored in escape.
- R10: `tmr_done` has no effect outside escape.
- R11: The outputs are decoded from the present state only. At most one of `esc_valid`, `cnt_clr` and `cnt_en` is high at any time, and `esc_valid` always equals `tmr_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| fwd_cmd | input | 1 | Forward motion command seen with the strobe |
| bwd_cmd | input | 1 | Reverse motion command seen with the strobe |
| upd_stb | input | 1 | One-cycle strobe marking a new motion command |
| cnt_tc | input | 1 | Terminal count (value 2'b11) from the external 2-bit counter |
| tmr_done | input | 1 | Movement timer has expired |
| esc_valid | output | 1 | Escape request is active |
| tmr_start | output | 1 | Start request for the movement timer |
| cnt_clr | output | 1 | Synchronous clear (load of 0) for the external counter |
| cnt_en | output | 1 | Increment enable for the external counter |

## Verification
Two functions can land in the same cycle. In the hold state, the counter can reach terminal count in the very cycle that a new reverse update arrives. The escape decision and the start of a new tracking cycle then compete for the next state. The bench provokes this by driving the reverse update in the first hold cycle after the third count pulse, while a behavioural model of the external counter feeds its terminal count back. The result is judged correct only if escape outputs appear on the next edge and the tracking pattern (all outputs low) does not.

// File: rtl/wedge_pkg.sv
package wedge_pkg;

  localparam int unsigned WD_STATE_W = 3;

  typedef enum logic [WD_STATE_W-1:0] {
    WD_IDLE   = 3'd0,
    WD_TRACK  = 3'd1,
    WD_BUMP   = 3'd2,
    WD_HOLD   = 3'd3,
    WD_ESCAPE = 3'd4
  } wd_state_e;

  typedef struct packed {
    logic valid;
    logic tstart;
    logic clr;
    logic en;
  } wd_out_t;

endpackage

// File: rtl/wedge_rst_sync.sv
module wedge_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= 1'b0;
        end else begin
          chain <= 1'b1;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '0;
        end else begin
          chain <= {chain[STAGES-2:0], 1'b1};
        end
      end
    end
  endgenerate

  assign rst_q_n = chain[STAGES-1];

endmodule

// File: rtl/wedge_next_state.sv
module wedge_next_state
  import wedge_pkg::*;
(
  input  wd_state_e state_q,
  input  logic      fwd_cmd,
  input  logic      bwd_cmd,
  input  logic      upd_stb,
  input  logic      cnt_tc,
  input  logic      tmr_done,
  output wd_state_e state_d
);

  always_comb begin
    state_d = WD_IDLE;
    case (state_q)
      WD_IDLE: begin
        if (upd_stb && bwd_cmd) state_d = WD_TRACK;
        else                    state_d = WD_IDLE;
      end
      WD_TRACK: begin
        if (!upd_stb)     state_d = WD_TRACK;
        else if (fwd_cmd) state_d = WD_BUMP;
        else if (bwd_cmd) state_d = WD_TRACK;
        else              state_d = WD_IDLE;
      end
      WD_BUMP: begin
        state_d = WD_HOLD;
      end
      WD_HOLD: begin
        if (cnt_tc)       state_d = WD_ESCAPE;
        else if (!upd_stb) state_d = WD_HOLD;
        else if (bwd_cmd) state_d = WD_TRACK;
        else              state_d = WD_IDLE;
      end
      WD_ESCAPE: begin
        if (tmr_done) state_d = WD_IDLE;
        else          state_d = WD_ESCAPE;
      end
      default: begin
        state_d = WD_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/wedge_state_reg.sv
module wedge_state_reg
  import wedge_pkg::*;
(
  input  logic      clk,
  input  logic      rst_q_n,
  input  wd_state_e state_d,
  output wd_state_e state_q
);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= WD_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/wedge_out_decode.sv
module wedge_out_decode
  import wedge_pkg::*;
(
  input  wd_state_e state_q,
  output wd_out_t   outs
);

  always_comb begin
    outs = '0;
    case (state_q)
      WD_IDLE:   outs.clr = 1'b1;
      WD_BUMP:   outs.en  = 1'b1;
      WD_ESCAPE: begin
        outs.valid  = 1'b1;
        outs.tstart = 1'b1;
      end
      default:   outs = '0;
    endcase
  end

endmodule

// File: rtl/wedge_detect.sv
module wedge_detect
  import wedge_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_cmd,
  input  logic bwd_cmd,
  input  logic upd_stb,
  input  logic cnt_tc,
  input  logic tmr_done,
  output logic esc_valid,
  output logic tmr_start,
  output logic cnt_clr,
  output logic cnt_en
);

  logic      rst_q_n;
  wd_state_e state_q;
  wd_state_e state_d;
  wd_out_t   outs;

  wedge_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  wedge_next_state u_ns (
    .state_q  (state_q),
    .fwd_cmd  (fwd_cmd),
    .bwd_cmd  (bwd_cmd),
    .upd_stb  (upd_stb),
    .cnt_tc   (cnt_tc),
    .tmr_done (tmr_done),
    .state_d  (state_d)
  );

  wedge_state_reg u_reg (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .state_d (state_d),
    .state_q (state_q)
  );

  wedge_out_decode u_dec (
    .state_q (state_q),
    .outs    (outs)
  );

  assign esc_valid = outs.valid;
  assign tmr_start = outs.tstart;
  assign cnt_clr   = outs.clr;
  assign cnt_en    = outs.en;

endmodule

// File: rtl/wedge_detect_chk.sv
module wedge_detect_chk
  import wedge_pkg::*;
(
  input logic      clk,
  input logic      run_n,
  input logic      fwd_cmd,
  input logic      bwd_cmd,
  input logic      upd_stb,
  input logic      cnt_tc,
  input logic      tmr_done,
  input logic      esc_valid,
  input logic      tmr_start,
  input logic      cnt_clr,
  input logic      cnt_en,
  input wd_state_e state_q
);

  // R2
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!run_n)
    (cnt_clr && !upd_stb) |=> cnt_clr);

  // R3
  enter_track_chk: assert property (@(posedge clk) disable iff (!run_n)
    (cnt_clr && upd_stb && bwd_cmd) |=> (!cnt_clr && !cnt_en && !esc_valid));

  // R4
  en_single_chk: assert property (@(posedge clk) disable iff (!run_n)
    cnt_en |=> !cnt_en);

  // R4
  en_then_hold_chk: assert property (@(posedge clk) disable iff (!run_n)
    cnt_en |=> (state_q == WD_HOLD));

  // R8
  tc_escape_chk: assert property (@(posedge clk) disable iff (!run_n)
    ((state_q == WD_HOLD) && cnt_tc) |=> esc_valid);

  // R9
  esc_stay_chk: assert property (@(posedge clk) disable iff (!run_n)
    (esc_valid && !tmr_done) |=> esc_valid);

  // R9
  esc_exit_chk: assert property (@(posedge clk) disable iff (!run_n)
    (esc_valid && tmr_done) |=> cnt_clr);

  // R11
  excl_chk: assert property (@(posedge clk) disable iff (!run_n)
    $onehot0({esc_valid, cnt_clr, cnt_en}));

  // R11
  pair_chk: assert property (@(posedge clk) disable iff (!run_n)
    (esc_valid == tmr_start));

endmodule

bind wedge_detect wedge_detect_chk u_chk (
  .clk       (clk),
  .run_n     (rst_q_n),
  .fwd_cmd   (fwd_cmd),
  .bwd_cmd   (bwd_cmd),
  .upd_stb   (upd_stb),
  .cnt_tc    (cnt_tc),
  .tmr_done  (tmr_done),
  .esc_valid (esc_valid),
  .tmr_start (tmr_start),
  .cnt_clr   (cnt_clr),
  .cnt_en    (cnt_en),
  .state_q   (state_q)
);

// File: tb/sim_wedge_detect.sv
`timescale 1ns/1ps
module sim_wedge_detect;

  localparam logic [3:0] XI = 4'b0010; // idle: clear only
  localparam logic [3:0] XZ = 4'b0000; // tracking or hold
  localparam logic [3:0] XB = 4'b0001; // count pulse
  localparam logic [3:0] XE = 4'b1100; // escape: valid + start

  logic clk = 1'b0;
  logic rst_n;
  logic fwd_cmd, bwd_cmd, upd_stb, tmr_done;
  logic cnt_tc;
  logic esc_valid, tmr_start, cnt_clr, cnt_en;
  logic [1:0] mcnt;

  int checks = 0;
  int failures = 0;

  logic [3:0] qexp[$];
  string      qtag[$];

  always #2.5 clk = ~clk;

  wedge_detect u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd_cmd   (fwd_cmd),
    .bwd_cmd   (bwd_cmd),
    .upd_stb   (upd_stb),
    .cnt_tc    (cnt_tc),
    .tmr_done  (tmr_done),
    .esc_valid (esc_valid),
    .tmr_start (tmr_start),
    .cnt_clr   (cnt_clr),
    .cnt_en    (cnt_en)
  );

  // environment: external 2-bit counter with synchronous clear
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mcnt <= 2'd0;
    else if (cnt_clr) mcnt <= 2'd0;
    else if (cnt_en)  mcnt <= mcnt + 2'd1;
  end
  assign cnt_tc = (mcnt == 2'b11);

  function automatic logic [3:0] outs_now();
    return {esc_valid, tmr_start, cnt_clr, cnt_en};
  endfunction

  // monitor: pops expectations after each rising edge
  always @(posedge clk) begin
    #1;
    if (qexp.size() > 0) begin
      logic [3:0] e;
      string      t;
      e = qexp.pop_front();
      t = qtag.pop_front();
      checks++;
      if (outs_now() !== e) begin
        failures++;
        $display("FAIL %s actual=%b expected=%b", t, outs_now(), e);
      end
    end
  end

  // driver: apply one cycle of inputs, queue the outputs expected after the edge
  task automatic step(input logic f, input logic b, input logic u, input logic t,
                      input logic [3:0] e, input string tag);
    @(negedge clk);
    fwd_cmd = f; bwd_cmd = b; upd_stb = u; tmr_done = t;
    qexp.push_back(e);
    qtag.push_back(tag);
  endtask

  task automatic one_cycle(input string tag);
    step(1'b0, 1'b1, 1'b1, 1'b0, XZ, tag);
    step(1'b1, 1'b0, 1'b1, 1'b0, XB, tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, XZ, tag);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0, XI, "R1 release");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fwd_cmd = 1'b0; bwd_cmd = 1'b0; upd_stb = 1'b0; tmr_done = 1'b0;
    step(1'b0, 1'b0, 1'b0, 1'b0, XI, "R1 reset state");
    step(1'b1, 1'b1, 1'b1, 1'b0, XI, "R1 inputs during reset");
    release_reset();

    // R2, R3, R10, R5, R4, R6
    step(1'b0, 1'b1, 1'b0, 1'b0, XI, "R2 bwd without update");
    step(1'b1, 1'b0, 1'b1, 1'b0, XI, "R3 fwd-only update in idle");
    step(1'b0, 1'b0, 1'b1, 1'b0, XI, "R3 empty update in idle");
    step(1'b0, 1'b0, 1'b0, 1'b1, XI, "R10 timer done in idle");
    step(1'b0, 1'b1, 1'b1, 1'b0, XZ, "R3 bwd update enters tracking");
    step(1'b0, 1'b0, 1'b0, 1'b1, XZ, "R10 timer done in tracking");
    step(1'b1, 1'b0, 1'b0, 1'b0, XZ, "R2 fwd without update");
    step(1'b0, 1'b1, 1'b1, 1'b0, XZ, "R5 repeated bwd stays tracking");
    step(1'b1, 1'b0, 1'b1, 1'b0, XB, "R4 fwd completes a cycle");
    step(1'b1, 1'b1, 1'b1, 1'b1, XZ, "R4 enable lasts one cycle");
    step(1'b0, 1'b0, 1'b0, 1'b0, XZ, "R6 hold waits");
    step(1'b0, 1'b0, 1'b1, 1'b0, XI, "R6 update without bwd leaves hold");

    // R6 count kept across re-tracking, R5 empty update clears it (R7)
    one_cycle("R4 cycle one");
    step(1'b0, 1'b1, 1'b1, 1'b0, XZ, "R6 bwd from hold keeps count");
    step(1'b1, 1'b0, 1'b1, 1'b0, XB, "R4 second pulse");
    step(1'b0, 1'b0, 1'b0, 1'b0, XZ, "R4 hold");
    step(1'b0, 1'b1, 1'b1, 1'b0, XZ, "R3 tracking");
    step(1'b0, 1'b0, 1'b1, 1'b0, XI, "R5 empty update in tracking");
    one_cycle("R7 restart cycle one");
    one_cycle("R7 restart cycle two");
    step(1'b0, 1'b0, 1'b0, 1'b0, XZ, "R7 count restarted, no escape yet");
    step(1'b0, 1'b1, 1'b1, 1'b0, XZ, "R6 bwd from hold");
    step(1'b1, 1'b0, 1'b1, 1'b0, XB, "R4 third pulse");
    step(1'b0, 1'b0, 1'b0, 1'b0, XZ, "R8 hold before terminal check");
    step(1'b0, 1'b1, 1'b1, 1'b0, XE, "R8 terminal count beats bwd update");
    step(1'b0, 1'b0, 1'b0, 1'b0, XE, "R9 escape holds");
    step(1'b1, 1'b1, 1'b1, 1'b0, XE, "R9 commands ignored in escape");
    step(1'b0, 1'b0, 1'b0, 1'b1, XI, "R9 timer done ends escape");

    // R4 both commands, plain escape, then asynchronous reset mid-escape
    step(1'b0, 1'b1, 1'b1, 1'b0, XZ, "R3 tracking");
    step(1'b1, 1'b1, 1'b1, 1'b0, XB, "R4 fwd wins when both set");
    step(1'b0, 1'b0, 1'b0, 1'b0, XZ, "R4 hold");
    one_cycle("R7 cycle two");
    one_cycle("R7 cycle three");
    step(1'b0, 1'b0, 1'b0, 1'b0, XE, "R8 escape after three cycles");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    checks++;
    if (outs_now() !== XI) begin
      failures++;
      $display("FAIL R1 async reset actual=%b expected=%b", outs_now(), XI);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, XI, "R1 held in reset");
    release_reset();
    one_cycle("R7 after reset cycle one");
    step(1'b0, 1'b0, 1'b0, 1'b0, XZ, "R7 reset cleared count");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule